// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the address that a synchronous burst memory uses on each cycle. When either of two start strobes is high at a rising clock edge, the generator takes the external address bus as the base of a new burst. It also takes the level of the order-select input at that edge. On every later edge where the advance input is high, it steps the two least significant address bits to the next beat. The upper address bits stay as they were loaded. The sequence stays inside a four-location block and wraps back to its first location after four steps.

The block is controlled by a small state machine with two states. `ST_IDLE` is the state after reset, when no burst has been loaded yet. In this state the output address is zero and advance has no effect. `ST_BURST` holds a loaded burst, and its beat counter counts advances modulo four.

The state machine has these transitions:
- `T_LOAD`: from `ST_IDLE` to `ST_BURST` when a strobe is high.
- `T_RELOAD`: from `ST_BURST` to `ST_BURST` when a strobe is high; this clears the beat counter.
- `T_STEP`: from `ST_BURST` to `ST_BURST` when advance is high and no strobe is high; this increments the beat counter.
- `T_HOLD`: the state and counter keep their values when neither a strobe nor advance is high.

A new address can be loaded on any cycle. A burst does not have to finish first.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and after reset until the first strobe, `cur_addr` is all zeros, and advance has no effect on it.
- R2: When `strobe_a` or `strobe_b` is high at a rising edge, `cur_addr` equals the sampled `ext_addr` after that edge. Values on `ext_addr` in cycles without a strobe are ignored.
- R3: In interleaved order, after n advances since the load, `cur_addr[1:0]` equals the loaded low bits XOR (n mod 4).
- R4: In linear order, after n advances since the load, `cur_addr[1:0]` equals (loaded low bits + n) mod 4.
- R5: `cur_addr[ADDR_W-1:2]` keeps the loaded upper bits for the whole burst. A wrap of the low bits never carries into the upper bits.
- R6: At an edge with advance low and no strobe high, `cur_addr` keeps its value.
- R7: A strobe and advance high at the same edge load the new address; the load wins. Both strobes high together act the same as one strobe.
- R8: The order is sampled at the loading edge: `order_linear` = 1 selects linear, and 0 selects interleaved. A value of 0 is the default when the input is tied low. Changes to `order_linear` during a burst have no effect until the next load.
- R9: After the fourth advance of a burst, `cur_addr` returns to the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; all inputs are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | External address captured when a burst starts |
| strobe_a | input | 1 | First burst-start strobe |
| strobe_b | input | 1 | Second burst-start strobe |
| advance | input | 1 | Steps the burst to its next beat |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order (default) |
| cur_addr | output | ADDR_W | Current internal burst address |

## Verification
Two functions can fall in the same cycle: loading a new burst and stepping the current one. The bench provokes this by raising a strobe and advance at the same edge partway through a burst. The result is judged correct only if the output equals the new external address with a beat count of zero; a stepped old address is a failure. A second overlap is a change of the order input in the middle of a burst while advances continue. This is judged against beat values that the bench computes from the order that was sampled at the load.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_st_e;

    typedef logic [BEAT_W-1:0] beat_t;

    function automatic beat_t order_step(input beat_t start, input beat_t beat, input logic linear);
        beat_t r;
        if (linear) r = start + beat;
        else        r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      advance,
    output burst_st_e state,
    output beat_t     beat
);

    burst_st_e state_q, state_d;
    beat_t     beat_q, beat_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = ST_BURST;
                    beat_d  = '0;
                end
            end
            ST_BURST: begin
                if (load) begin
                    beat_d = '0;
                end else if (advance) begin
                    beat_d = beat_q + beat_t'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
        endcase
    end

    always_comb begin
        state = state_q;
        beat  = beat_q;
    end

endmodule

// File: rtl/burst_capture.sv
module burst_capture #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              order_linear,
    output logic [ADDR_W-1:0] base,
    output logic              mode_lin
);

    logic [ADDR_W-1:0] base_q;
    logic              mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= 1'b0;
        end else if (load) begin
            base_q <= ext_addr;
            mode_q <= order_linear;
        end
    end

    assign base     = base_q;
    assign mode_lin = mode_q;

endmodule

// File: rtl/burst_order.sv
module burst_order
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  burst_st_e         state,
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    input  logic              mode_lin,
    output logic [ADDR_W-1:0] addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    beat_t low;

    always_comb begin
        low = order_step(base[BEAT_W-1:0], beat, mode_lin);
    end

    generate
        if (HI_W > 0) begin : g_hi
            always_comb begin
                unique case (state)
                    ST_IDLE:  addr = '0;
                    ST_BURST: addr = {base[ADDR_W-1:BEAT_W], low};
                    default:  addr = '0;
                endcase
            end
        end else begin : g_lo
            always_comb begin
                unique case (state)
                    ST_IDLE:  addr = '0;
                    ST_BURST: addr = low;
                    default:  addr = '0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic              advance,
    input  logic              order_linear,
    output logic [ADDR_W-1:0] cur_addr
);

    logic              load;
    burst_st_e         fsm_state;
    beat_t             fsm_beat;
    logic [ADDR_W-1:0] base;
    logic              mode_q;

    assign load = strobe_a | strobe_b;

    burst_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .state   (fsm_state),
        .beat    (fsm_beat)
    );

    burst_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .ext_addr     (ext_addr),
        .order_linear (order_linear),
        .base         (base),
        .mode_lin     (mode_q)
    );

    burst_order #(.ADDR_W(ADDR_W)) u_ord (
        .state    (fsm_state),
        .base     (base),
        .beat     (fsm_beat),
        .mode_lin (mode_q),
        .addr     (cur_addr)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strobe_a,
    input logic              strobe_b,
    input logic              advance,
    input logic [ADDR_W-1:0] cur_addr,
    input burst_st_e         fsm_state,
    input logic              mode_q
);

    logic any_strobe;
    assign any_strobe = strobe_a | strobe_b;

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && !any_strobe) |=> (cur_addr == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> (cur_addr == $past(ext_addr)));

    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_BURST && !any_strobe) |=> $stable(cur_addr[ADDR_W-1:2]));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && !advance) |=> $stable(cur_addr));

    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_BURST && mode_q && advance && !any_strobe)
        |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

    p_ilv_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_BURST && !mode_q && advance && !any_strobe)
        |=> ((cur_addr[0] ^ $past(cur_addr[0])) == 1'b1));

    p_mode_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> $stable(mode_q));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .strobe_a  (strobe_a),
    .strobe_b  (strobe_b),
    .advance   (advance),
    .cur_addr  (cur_addr),
    .fsm_state (fsm_state),
    .mode_q    (mode_q)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ext_addr;
    logic          strobe_a, strobe_b, advance, order_linear;
    logic [AW-1:0] cur_addr;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_addr     (ext_addr),
        .strobe_a     (strobe_a),
        .strobe_b     (strobe_b),
        .advance      (advance),
        .order_linear (order_linear),
        .cur_addr     (cur_addr)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        logic [AW-1:0] a, b;
        logic [AW-3:0] hi;
        logic [1:0]    lo;
        int            n;
        rst_n = 1'b0; ext_addr = '0; strobe_a = 0; strobe_b = 0;
        advance = 0; order_linear = 0;
        repeat (3) tick();
        chk("R1 reset", cur_addr, '0);
        rst_n = 1'b1;
        advance = 1'b1;
        ext_addr = 18'h3ABCD;
        tick();
        chk("R1 advance before load", cur_addr, '0);
        tick();
        chk("R1 ext_addr without strobe", cur_addr, '0);
        advance = 1'b0;

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int ub = 0; ub < 2; ub++) begin
                    hi = 16'(m * 16'h5A31 + s * 16'h0F07 + ub * 16'h8123 + 16'h0411);
                    a  = {hi, 2'(s)};
                    ext_addr = a; strobe_a = (ub == 0); strobe_b = (ub == 1);
                    order_linear = 1'(m);
                    tick();
                    strobe_a = 0; strobe_b = 0; ext_addr = ~a;
                    chk("R2 load", cur_addr, a);
                    n = 0;
                    for (int k = 0; k < 8; k++) begin
                        advance = ((k % 3) != 2);
                        if (k == 1) order_linear = 1'(!m);
                        tick();
                        if (advance) n++;
                        lo = (m == 1) ? 2'(s + n) : (2'(s) ^ 2'(n));
                        if (k == 1)
                            chk("R8 mode change mid-burst", cur_addr, {hi, lo});
                        else if (!advance)
                            chk("R6 hold", cur_addr, {hi, lo});
                        else if (m == 1)
                            chk("R4 linear", cur_addr, {hi, lo});
                        else
                            chk("R3 interleaved", cur_addr, {hi, lo});
                        chk("R5 upper bits", {cur_addr[AW-1:2], 2'b00}, {hi, 2'b00});
                        if (advance && n == 4) chk("R9 wrap", cur_addr, a);
                    end
                    advance = 0; order_linear = 1'(m);
                end
            end
        end

        // R7: strobe with advance mid-burst
        a = 18'h12345; b = 18'h2F00E;
        ext_addr = a; strobe_a = 1; order_linear = 1; tick();
        strobe_a = 0; advance = 1; tick();
        chk("R4 step before restart", cur_addr, 18'h12346);
        ext_addr = b; strobe_b = 1; advance = 1; order_linear = 0; tick();
        chk("R7 load beats advance", cur_addr, b);
        strobe_b = 0; tick();
        chk("R7 restart order interleaved", cur_addr, {b[AW-1:2], 2'b11});
        ext_addr = a; strobe_a = 1; strobe_b = 1; tick();
        chk("R7 both strobes", cur_addr, a);
        strobe_a = 0; strobe_b = 0; advance = 0; tick();
        chk("R6 hold after load", cur_addr, a);
        advance = 1; tick();
        chk("R8 default interleaved", cur_addr, {a[AW-1:2], 2'b01 ^ 2'b01});
        advance = 0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule